// File: doc/BRIEF.md
# Prioritised Interrupt Router with Claim and Completion

This block gathers level-sensitive interrupt request lines from a parameterised set of sources and routes them to several target contexts. Each source carries a small priority value. Each context has its own enable mask, a priority threshold and a claim/completion register. A context's interrupt output is high while at least one source qualifies for it.

A handler reads its context's claim register to learn which source to service. That read returns the best qualifying source and marks it as in service, so the source is hidden from every context. Once the handler finishes, it writes the same source number back to the claim register to complete it. All registers sit behind a simple 32-bit register bus. The bus has separate read and write strobes and byte addresses. Read data comes back one cycle after the read strobe.

Top module: `irqc_top`

## Requirements
- R1: After reset every priority, pending, enable and threshold register reads zero, every claim read returns 0, `ctx_irq` is all low and `bus_rvalid` is low.
- R2: The priority of source n (n ≥ 1) is read and written at byte address 4·(n−1). Only the low 3 bits of a write are kept; the remaining bits read back as zero.
- R3: The threshold of context c sits at 0x4000 + c·0x1000. A write is taken only when the whole 32-bit value is at most 7. A larger value leaves the threshold unchanged.
- R4: Pending word w at 0x1000 + 4w holds, in bit b, source 32w+b. Each pending bit copies its request line one clock later. Writes to this region change nothing.
- R5: Enable word w of context c sits at 0x2000 + c·0x80 + 4w. It is read/write and independent per context. Bits for source numbers at or above the source count read zero.
- R6: `ctx_irq[c]` is high exactly when some source is pending, not claimed, enabled for c, and has a priority strictly above c's threshold. The output reflects a new request or register write one clock after it.
- R7: A read of context c's claim register (threshold address + 4) returns the qualifying source with the highest priority. On a tie the lowest source number wins, and the read returns 0 when nothing qualifies. The value appears on `bus_rdata` with `bus_rvalid` one clock after the strobe.
- R8: A claim read that returns a non-zero source marks that source claimed and clears its pending bit for that clock. A claimed source qualifies for no context until it is completed.
- R9: Writing a value below the source count (8) to any context's claim register clears that source's claimed mark. Values of 8 or more are ignored.
- R10: An access whose address has bit 1 or bit 0 set is ignored. The read returns 0 and the write changes no register.
- R11: A read of an unmapped or unused address returns 0, and a write there changes nothing. Examples are an enable word beyond the source count, context offset 8, and the priority slot past the last source.
- R12: Source 0 has no priority register. Its request line is ignored, so it never becomes pending, claimed or selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | NUM_SRC | Level request line per source |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one clock after bus_rd |
| ctx_irq | output | NUM_CTX | Interrupt output per context |

## Verification
The selection logic is swept over four priority, enable and request patterns. Each pattern is run at all eight threshold values, with the two contexts given opposite thresholds. This separates a strict comparison from a non-strict one, and a per-context mask from a shared one. Claims on both contexts within a sweep step show whether a claimed mark is global. A hand-built pattern with equal priorities checks the lowest-number tie rule. A completion value whose low bits alias a claimed source checks that out-of-range values are rejected in full. A back-to-back claim and pending read catches the one-clock pending clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned BUS_W      = 32;
   localparam int unsigned WORD_BYTES = 4;

   // number of 32-bit words needed for one bit per source
   function automatic int unsigned words_for(input int unsigned nbits);
      return (nbits + BUS_W - 1) / BUS_W;
   endfunction
endpackage

// File: rtl/irqc_srcstate.sv
module irqc_srcstate #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic [NUM_SRC-1:0] take,
   input  logic [NUM_SRC-1:0] done,
   output logic [NUM_SRC-1:0] pend_q,
   output logic [NUM_SRC-1:0] claim_q
);
   logic [NUM_SRC-1:0] pend_d;

   always_comb begin
      pend_d    = src_req & ~take;
      pend_d[0] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         claim_q <= '0;
      end else begin
         pend_q  <= pend_d;
         claim_q <= (claim_q & ~done) | take;
      end
   end
endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned PRIO_W  = 3,
   localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0]             cand,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
   input  logic [PRIO_W-1:0]              thr,
   output logic [ID_W-1:0]                win_id,
   output logic                           found
);
   logic [PRIO_W-1:0] best_p;

   // strict compare keeps the lowest-numbered source on a tie
   always_comb begin
      win_id = '0;
      best_p = thr;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (s != 0 && cand[s] && prio[s] > best_p) begin
            win_id = ID_W'(s);
            best_p = prio[s];
         end
      end
      found = (win_id != '0);
   end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SRC    = 8,
   parameter int unsigned NUM_CTX    = 2,
   parameter int unsigned PRIO_W     = 3,
   parameter int unsigned NUM_LEVELS = 7,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned PEND_BASE  = 32'h1000,
   parameter int unsigned EN_BASE    = 32'h2000,
   parameter int unsigned EN_STRIDE  = 32'h80,
   parameter int unsigned CTX_BASE   = 32'h4000,
   parameter int unsigned CTX_STRIDE = 32'h1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               bus_rvalid,
   output logic [NUM_CTX-1:0] ctx_irq
);
   localparam int unsigned ID_W  = $clog2(NUM_SRC);
   localparam int unsigned WORDS = words_for(NUM_SRC);
   localparam int unsigned PAD_W = WORDS * BUS_W;
   localparam int unsigned EN_SH = $clog2(EN_STRIDE);
   localparam int unsigned CX_SH = $clog2(CTX_STRIDE);
   localparam logic [ADDR_W-1:0] PRIO_END_A = ADDR_W'(WORD_BYTES * (NUM_SRC - 1));
   localparam logic [ADDR_W-1:0] PEND_A     = ADDR_W'(PEND_BASE);
   localparam logic [ADDR_W-1:0] PEND_LEN_A = ADDR_W'(WORD_BYTES * WORDS);
   localparam logic [ADDR_W-1:0] EN_A       = ADDR_W'(EN_BASE);
   localparam logic [ADDR_W-1:0] EN_LEN_A   = ADDR_W'(NUM_CTX * EN_STRIDE);
   localparam logic [ADDR_W-1:0] CX_A       = ADDR_W'(CTX_BASE);
   localparam logic [ADDR_W-1:0] CX_LEN_A   = ADDR_W'(NUM_CTX * CTX_STRIDE);

   // elaboration-time parameter checks
   if (NUM_SRC < 2 || NUM_SRC > 1024) begin : g_bad_src
      $error("irqc_top: NUM_SRC out of range");
   end
   if (NUM_CTX < 1 || NUM_CTX > 64) begin : g_bad_ctx
      $error("irqc_top: NUM_CTX out of range");
   end
   if (PRIO_W < 1 || NUM_LEVELS >= (1 << PRIO_W)) begin : g_bad_prio
      $error("irqc_top: NUM_LEVELS does not fit PRIO_W");
   end
   if ((EN_STRIDE & (EN_STRIDE - 1)) != 0 || EN_STRIDE < 8 ||
       EN_STRIDE < WORD_BYTES * WORDS) begin : g_bad_en
      $error("irqc_top: EN_STRIDE must be a power of two holding all words");
   end
   if ((CTX_STRIDE & (CTX_STRIDE - 1)) != 0 || CTX_STRIDE < 8) begin : g_bad_cx
      $error("irqc_top: CTX_STRIDE must be a power of two of at least 8");
   end
   if (CTX_BASE + NUM_CTX * CTX_STRIDE > (1 << ADDR_W) ||
       EN_BASE + NUM_CTX * EN_STRIDE > (1 << ADDR_W)) begin : g_bad_map
      $error("irqc_top: register map exceeds address space");
   end

   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
   logic [NUM_CTX-1:0][NUM_SRC-1:0] en_q;
   logic [NUM_CTX-1:0][PRIO_W-1:0]  thr_q;
   logic [NUM_CTX-1:0][ID_W-1:0]    win_id;
   logic [NUM_SRC-1:0] pend_q, claim_q, take, done;

   // address decode
   logic              aligned, hit_prio, hit_pend, hit_en, hit_cx, hit_thr, hit_clm;
   logic [ID_W-1:0]   prio_id;
   logic [ADDR_W-1:0] pd_off, en_off, cx_off;
   int                pd_word, en_ctx, en_word, cx_ctx, cx_reg;

   always_comb begin
      aligned  = (bus_addr[1:0] == 2'b00);
      hit_prio = aligned && (bus_addr < PRIO_END_A);
      prio_id  = ID_W'(bus_addr >> 2) + ID_W'(1);
      pd_off   = bus_addr - PEND_A;
      hit_pend = aligned && (bus_addr >= PEND_A) && (pd_off < PEND_LEN_A);
      pd_word  = int'(pd_off >> 2);
      en_off   = bus_addr - EN_A;
      en_ctx   = int'(en_off >> EN_SH);
      en_word  = int'(en_off[EN_SH-1:2]);
      hit_en   = aligned && (bus_addr >= EN_A) && (en_off < EN_LEN_A) && (en_word < int'(WORDS));
      cx_off   = bus_addr - CX_A;
      cx_ctx   = int'(cx_off >> CX_SH);
      cx_reg   = int'(cx_off[CX_SH-1:0]);
      hit_cx   = aligned && (bus_addr >= CX_A) && (cx_off < CX_LEN_A);
      hit_thr  = hit_cx && (cx_reg == 0);
      hit_clm  = hit_cx && (cx_reg == int'(WORD_BYTES));
   end

   // claim (read side effect) and completion (write) vectors
   always_comb begin
      take = '0;
      done = '0;
      for (int s = 1; s < NUM_SRC; s++) begin
         for (int c = 0; c < NUM_CTX; c++) begin
            if (bus_rd && hit_clm && cx_ctx == c && win_id[c] == ID_W'(s)) take[s] = 1'b1;
         end
         if (bus_wr && hit_clm && bus_wdata == 32'(s)) done[s] = 1'b1;
      end
   end

   irqc_srcstate #(.NUM_SRC(NUM_SRC)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_req (src_req),
      .take    (take),
      .done    (done),
      .pend_q  (pend_q),
      .claim_q (claim_q)
   );

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_q <= '0;
         en_q   <= '0;
         thr_q  <= '0;
      end else if (bus_wr) begin
         for (int s = 1; s < NUM_SRC; s++) begin
            if (hit_prio && prio_id == ID_W'(s)) prio_q[s] <= bus_wdata[PRIO_W-1:0];
         end
         for (int c = 0; c < NUM_CTX; c++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
               if (hit_en && en_ctx == c && en_word == s / 32) en_q[c][s] <= bus_wdata[s % 32];
            end
            if (hit_thr && cx_ctx == c && bus_wdata <= 32'(NUM_LEVELS)) thr_q[c] <= bus_wdata[PRIO_W-1:0];
         end
      end
   end

   // per-context selection
   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      irqc_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_sel (
         .cand   (pend_q & ~claim_q & en_q[c]),
         .prio   (prio_q),
         .thr    (thr_q[c]),
         .win_id (win_id[c]),
         .found  (ctx_irq[c])
      );
   end

   // read mux
   logic [31:0]      rdata_d;
   logic [PAD_W-1:0] pad;

   always_comb begin
      rdata_d = '0;
      pad     = '0;
      for (int s = 1; s < NUM_SRC; s++) begin
         if (hit_prio && prio_id == ID_W'(s)) rdata_d = 32'(prio_q[s]);
      end
      if (hit_pend) begin
         pad = PAD_W'(pend_q);
         for (int w = 0; w < WORDS; w++) begin
            if (pd_word == w) rdata_d = pad[w*32 +: 32];
         end
      end
      for (int c = 0; c < NUM_CTX; c++) begin
         if (hit_en && en_ctx == c) begin
            pad = PAD_W'(en_q[c]);
            for (int w = 0; w < WORDS; w++) begin
               if (en_word == w) rdata_d = pad[w*32 +: 32];
            end
         end
         if (hit_thr && cx_ctx == c) rdata_d = 32'(thr_q[c]);
         if (hit_clm && cx_ctx == c) rdata_d = 32'(win_id[c]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= bus_rd;
         if (bus_rd) bus_rdata <= rdata_d;
      end
   end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
   parameter int unsigned NUM_SRC    = 8,
   parameter int unsigned NUM_CTX    = 2,
   parameter int unsigned PRIO_W     = 3,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned CTX_BASE   = 32'h4000,
   parameter int unsigned CTX_STRIDE = 32'h1000,
   localparam int unsigned ID_W      = $clog2(NUM_SRC)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        bus_rd,
   input logic                        bus_wr,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic [31:0]                 bus_rdata,
   input logic                        bus_rvalid,
   input logic [NUM_CTX-1:0]          ctx_irq,
   input logic [NUM_SRC-1:0]          pend_q,
   input logic [NUM_SRC-1:0]          claim_q,
   input logic [NUM_CTX*NUM_SRC-1:0]  en_q,
   input logic [NUM_CTX*PRIO_W-1:0]   thr_q,
   input logic [NUM_SRC*PRIO_W-1:0]   prio_q
);
   logic [ADDR_W-1:0] off;
   logic              clm_now, was_clm;

   always_comb begin
      off     = bus_addr - ADDR_W'(CTX_BASE);
      clm_now = bus_rd && (bus_addr >= ADDR_W'(CTX_BASE)) &&
                (off < ADDR_W'(NUM_CTX * CTX_STRIDE)) &&
                ((off & ADDR_W'(CTX_STRIDE - 1)) == ADDR_W'(4));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) was_clm <= 1'b0;
      else        was_clm <= clm_now;
   end

   assert_claim_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid && was_clm && bus_rdata != 32'd0 |-> claim_q[bus_rdata[ID_W-1:0]]);

   assert_unaligned_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr[1:0] != 2'b00 |=> bus_rdata == 32'd0);

   assert_unaligned_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr[1:0] != 2'b00 |=> $stable(en_q) && $stable(thr_q) && $stable(prio_q));

   assert_src0_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q[0] && !claim_q[0]);

   assert_no_irq_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q & ~claim_q) == '0 |-> ctx_irq == '0);
endmodule

bind irqc_top irqc_chk #(
   .NUM_SRC    (NUM_SRC),
   .NUM_CTX    (NUM_CTX),
   .PRIO_W     (PRIO_W),
   .ADDR_W     (ADDR_W),
   .CTX_BASE   (CTX_BASE),
   .CTX_STRIDE (CTX_STRIDE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_rd     (bus_rd),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .bus_rvalid (bus_rvalid),
   .ctx_irq    (ctx_irq),
   .pend_q     (pend_q),
   .claim_q    (claim_q),
   .en_q       (en_q),
   .thr_q      (thr_q),
   .prio_q     (prio_q)
);

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  src_req = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic [1:0]  ctx_irq;

   int checks = 0;
   int failures = 0;

   int         pr_m [8];
   logic [7:0] en_m [2];
   int         thr_m [2];
   logic [7:0] req_m;
   logic [7:0] clm_m;

   always #2.5 clk = ~clk;

   irqc_top dut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .ctx_irq(ctx_irq)
   );

   function automatic logic [15:0] a_prio(input int n); return 16'(4 * (n - 1)); endfunction
   function automatic logic [15:0] a_en(input int c);   return 16'(32'h2000 + c * 32'h80); endfunction
   function automatic logic [15:0] a_thr(input int c);  return 16'(32'h4000 + c * 32'h1000); endfunction
   function automatic logic [15:0] a_clm(input int c);  return 16'(32'h4004 + c * 32'h1000); endfunction
   localparam logic [15:0] A_PEND = 16'h1000;

   function automatic int exp_win(input int c);
      int best = 0;
      int bp = thr_m[c];
      for (int n = 1; n < 8; n++) begin
         if (req_m[n] && !clm_m[n] && en_m[c][n] && pr_m[n] > bp) begin
            best = n;
            bp = pr_m[n];
         end
      end
      return best;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic rdchk(input logic [15:0] a, input logic [31:0] exp, input string tag);
      logic [31:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   task automatic claim_exp(input int c, input int exp, input string tag);
      logic [31:0] d;
      rd(a_clm(c), d);
      chk(tag, d, 32'(exp));
      if (exp != 0) clm_m[exp] = 1'b1;
   endtask

   task automatic complete_all();
      for (int n = 1; n < 8; n++) begin
         if (clm_m[n]) begin
            wr(a_clm(0), 32'(n));
            clm_m[n] = 1'b0;
         end
      end
   endtask

   task automatic set_prio(input int n, input int v);
      wr(a_prio(n), 32'(v));
      pr_m[n] = v;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] d1, d2;
      for (int n = 0; n < 8; n++) pr_m[n] = 0;
      en_m[0] = '0; en_m[1] = '0; thr_m[0] = 0; thr_m[1] = 0;
      req_m = '0; clm_m = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", 32'(ctx_irq), 32'd0);
      chk("R1 rvalid", 32'(bus_rvalid), 32'd0);
      for (int n = 1; n < 8; n++) rdchk(a_prio(n), 32'd0, "R1 prio");
      rdchk(A_PEND, 32'd0, "R1 pend");
      for (int c = 0; c < 2; c++) begin
         rdchk(a_en(c), 32'd0, "R1 en");
         rdchk(a_thr(c), 32'd0, "R1 thr");
         rdchk(a_clm(c), 32'd0, "R1 claim");
      end

      // R2 priority width
      for (int n = 1; n < 8; n++) wr(a_prio(n), 32'hFFFF_FFF0 | 32'(n));
      for (int n = 1; n < 8; n++) rdchk(a_prio(n), 32'(n & 7), "R2 prio low bits");
      rdchk(a_prio(8), 32'd0, "R11 prio past last");

      // R3 threshold acceptance
      wr(a_thr(0), 32'd8);
      rdchk(a_thr(0), 32'd0, "R3 thr 8 dropped");
      wr(a_thr(0), 32'd7);
      rdchk(a_thr(0), 32'd7, "R3 thr 7 taken");
      wr(a_thr(0), 32'h0000_0103);
      rdchk(a_thr(0), 32'd7, "R3 thr wide dropped");
      rdchk(a_thr(1), 32'd0, "R3 thr other ctx");
      wr(a_thr(0), 32'd0);

      // R4 pending follows request, R12 source 0 ignored
      src_req = 8'hA7;
      @(negedge clk);
      rdchk(A_PEND, 32'h0000_00A6, "R4 pend R12");
      wr(A_PEND, 32'hFFFF_FFFF);
      rdchk(A_PEND, 32'h0000_00A6, "R4 pend write ignored");
      src_req = 8'h00;
      @(negedge clk);

      // R5 enable per context
      wr(a_en(0), 32'hFFFF_FF5A);
      wr(a_en(1), 32'h0000_00C3);
      rdchk(a_en(0), 32'h0000_005A, "R5 en ctx0");
      rdchk(a_en(1), 32'h0000_00C3, "R5 en ctx1");

      // R11 unmapped
      rdchk(16'h2004, 32'd0, "R11 en word beyond");
      wr(16'h2004, 32'hFFFF_FFFF);
      rdchk(a_en(0), 32'h0000_005A, "R11 en word beyond write");
      rdchk(16'h4008, 32'd0, "R11 ctx offset 8");
      rdchk(16'h0800, 32'd0, "R11 hole");

      // R10 unaligned
      wr(16'h0001, 32'd0);
      rdchk(a_prio(1), 32'd1, "R10 unaligned write");
      rdchk(16'h2001, 32'd0, "R10 unaligned read");

      // R12 only source 0 enabled and requesting
      for (int n = 1; n < 8; n++) set_prio(n, 7);
      wr(a_en(0), 32'h01); en_m[0] = 8'h01;
      wr(a_en(1), 32'h01); en_m[1] = 8'h01;
      src_req = 8'h01; req_m = 8'h01;
      @(negedge clk);
      chk("R12 irq", 32'(ctx_irq), 32'd0);
      claim_exp(0, 0, "R12 claim");

      // R6 R7 R8 R9 sweep
      for (int p = 0; p < 4; p++) begin
         for (int n = 1; n < 8; n++) set_prio(n, (n * (2 * p + 3) + p) % 8);
         en_m[0] = 8'hFF & ~(8'h02 << p);
         en_m[1] = 8'h3C | (8'h81 >> p);
         wr(a_en(0), 32'(en_m[0]));
         wr(a_en(1), 32'(en_m[1]));
         req_m = 8'hFF & ~(8'h80 >> p);
         src_req = req_m;
         @(negedge clk);
         for (int t = 0; t < 8; t++) begin
            thr_m[0] = t; thr_m[1] = 7 - t;
            wr(a_thr(0), 32'(t));
            wr(a_thr(1), 32'(7 - t));
            chk("R6 irq sweep", 32'(ctx_irq), {30'd0, exp_win(1) != 0, exp_win(0) != 0});
            claim_exp(0, exp_win(0), "R7 claim ctx0 sweep");
            claim_exp(1, exp_win(1), "R7 claim ctx1 sweep");
            chk("R8 irq after claim", 32'(ctx_irq), {30'd0, exp_win(1) != 0, exp_win(0) != 0});
            complete_all();
         end
      end

      // R7 tie, R8 masking across contexts
      set_prio(1, 1); set_prio(2, 5); set_prio(3, 6); set_prio(4, 1);
      set_prio(5, 5); set_prio(6, 1); set_prio(7, 1);
      thr_m[0] = 0; thr_m[1] = 0;
      wr(a_thr(0), 32'd0); wr(a_thr(1), 32'd0);
      en_m[0] = 8'hFE; en_m[1] = 8'hFE;
      wr(a_en(0), 32'hFE); wr(a_en(1), 32'hFE);
      req_m = 8'hFF; src_req = 8'hFF;
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a_clm(0);
      @(negedge clk);
      bus_addr = A_PEND;
      d1 = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
      d2 = bus_rdata;
      chk("R7 best priority", d1, 32'd3);
      chk("R8 pending cleared", d2, 32'h0000_00F6);
      clm_m[3] = 1'b1;
      claim_exp(1, 2, "R7 tie lowest R8 shared claim");
      claim_exp(0, 5, "R7 next");
      claim_exp(0, 1, "R7 tie low prio");
      wr(a_thr(0), 32'd1); thr_m[0] = 1;
      claim_exp(0, 0, "R7 none above thr");
      chk("R6 equal thr low", 32'(ctx_irq[0]), 32'd0);
      chk("R6 other ctx high", 32'(ctx_irq[1]), 32'd1);

      // R9 completion
      wr(a_clm(0), 32'd10);
      claim_exp(1, 4, "R9 large id ignored");
      wr(a_clm(1), 32'd3); clm_m[3] = 1'b0;
      claim_exp(1, 3, "R9 completed reclaims");
      complete_all();
      wr(a_thr(0), 32'd0); thr_m[0] = 0;
      claim_exp(0, 3, "R9 all completed");
      complete_all();
      src_req = 8'h00; req_m = 8'h00;
      @(negedge clk);
      chk("R6 idle", 32'(ctx_irq), 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule